// File: doc/BRIEF.md
# Interpolator Staging Buffer

This block sits between an upsampling interpolator and the low-pass FIR that follows it. It holds one group of four samples: two consecutive input samples in the outer slots (slot 0 and slot 3), and the two samples the interpolator computes between them in the inner slots (slot 1 and slot 2). The block takes the two outer samples from the input stream and offers them as a pair to the interpolator. It then collects the two inner samples and streams all four to the filter in time order. The group is released and cleared only when the filter gives a separate group acknowledge.

Every data interface is valid/ready. A transfer takes place on a rising edge where valid and ready are both high. The block never raises a ready because it sees a valid. Only one of its own readies or valids is open at any time, so an upstream stage that holds valid while the block is busy is simply stalled, and no sample is dropped. A downstream stage that holds `m_ready` low freezes the output word. The later input sample of each group is kept as the earlier sample of the next group, so each later group needs just one new input sample. The core clock is meant to run at a whole multiple of the sample rate, which leaves enough idle cycles for the group sequence to finish between input samples. `ovf` warns when that budget is overrun.

Top module: `interp_stage_buf`

## Requirements
- R1: While `rst_n` is low, `s_ready`, `pair_valid`, `mid_ready`, `m_valid`, `m_last` and `ovf` are low and `pair_a`/`pair_b` read zero. `s_ready` is high after the first rising edge that follows reset release.
- R2: After two input samples are accepted, `pair_valid` is high with `pair_a` equal to the earlier sample and `pair_b` equal to the later one. Both stay stable until a `pair_ready` handshake.
- R3: At most one of `s_ready`, `pair_valid`, `mid_ready` and `m_valid` is high in any cycle. No input sample is accepted between the group's later sample and the group acknowledge.
- R4: `mid_ready` is high from the cycle after the pair handshake through exactly two `mid_data` transfers. The first transfer fills slot 1 and the second fills slot 2. After that, `mid_ready` is low.
- R5: The filter receives, one word per `m_valid`/`m_ready` handshake, the earlier input, the first interpolated sample, the second interpolated sample and the later input, in that order. `m_last` is high with the fourth word only.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold their values into the next cycle.
- R7: After the fourth word, `m_valid` and `s_ready` stay low until `flt_ack` is seen high on a rising edge. In the next cycle `s_ready` is high.
- R8: On the group acknowledge, slots 1 to 3 are cleared and slot 0 takes the old later sample. `pair_a` then shows that sample and `pair_b` shows zero, and one new input sample completes the next pair.
- R9: `ovf` is high in the cycle after any cycle in which `s_valid` was high while the block was streaming to, or waiting on, the filter. In every other case it is low.
- R10: `flt_ack` has no effect unless the block is waiting for the group acknowledge. An early pulse neither shortens the four-word output nor releases the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block accepts an input sample |
| s_data | input | DATA_W | Input sample |
| pair_valid | output | 1 | Outer pair offered to the interpolator |
| pair_ready | input | 1 | Interpolator takes the pair |
| pair_a | output | DATA_W | Slot 0 (earlier input sample) |
| pair_b | output | DATA_W | Slot 3 (later input sample) |
| mid_valid | input | 1 | Interpolated sample valid |
| mid_ready | output | 1 | Block accepts an interpolated sample |
| mid_data | input | DATA_W | Interpolated sample |
| m_valid | output | 1 | Output word valid toward the filter |
| m_ready | input | 1 | Filter takes the output word |
| m_data | output | DATA_W | Output word |
| m_last | output | 1 | Marks the fourth word of a group |
| flt_ack | input | 1 | Filter releases the group |
| ovf | output | 1 | Input arrived while draining |

## Verification
The bench stalls every handshake for random stretches and checks the word order and the hold of `m_data`. A design that advanced its read pointer without a handshake would skip or repeat a word, and one that swapped slots would deliver the later input too early. It checks that the old later sample turns into `pair_a` after the acknowledge and that `pair_b` reads zero. A block that forgot the reuse would wait for two samples and hang, and one that skipped the clear would show a stale `pair_b`. It pulses `flt_ack` in the middle of a stream, where a block that did not ignore it would cut the group short. It raises `s_valid` while the block waits on the filter and while it waits on the interpolator, so that `ovf` must fire in the first case and stay quiet in the second. All-zero and all-ones samples are included as directed values.

// File: rtl/isb_pkg.sv
package isb_pkg;
  localparam int NUM_SLOTS  = 4;
  localparam int SLOT_FIRST = 0;
  localparam int SLOT_LAST  = NUM_SLOTS - 1;
  localparam int IDX_W      = $clog2(NUM_SLOTS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_A,
    ST_LOAD_B,
    ST_WAIT_INTERP,
    ST_LOAD_MID1,
    ST_LOAD_MID2,
    ST_PRESENT,
    ST_WAIT_ACK
  } isb_state_e;
endpackage

// File: rtl/isb_ctrl.sv
module isb_ctrl
  import isb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             pair_ready,
  input  logic             mid_valid,
  input  logic             m_ready,
  input  logic             flt_ack,
  output logic             s_ready,
  output logic             pair_valid,
  output logic             mid_ready,
  output logic             m_valid,
  output logic             m_last,
  output logic [NUM_SLOTS-1:0] ld_en,
  output logic             recycle,
  output logic [IDX_W-1:0] rd_idx,
  output logic             ovf
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_LAST);

  isb_state_e       state_q, state_d;
  logic [IDX_W-1:0] rd_idx_q;
  logic             ovf_q;
  logic             draining;

  always_comb begin
    state_d    = state_q;
    ld_en      = '0;
    recycle    = 1'b0;
    s_ready    = 1'b0;
    pair_valid = 1'b0;
    mid_ready  = 1'b0;
    m_valid    = 1'b0;
    case (state_q)
      ST_IDLE: state_d = ST_LOAD_A;
      ST_LOAD_A: begin
        s_ready = 1'b1;
        if (s_valid) begin
          ld_en[SLOT_FIRST] = 1'b1;
          state_d = ST_LOAD_B;
        end
      end
      ST_LOAD_B: begin
        s_ready = 1'b1;
        if (s_valid) begin
          ld_en[SLOT_LAST] = 1'b1;
          state_d = ST_WAIT_INTERP;
        end
      end
      ST_WAIT_INTERP: begin
        pair_valid = 1'b1;
        if (pair_ready) state_d = ST_LOAD_MID1;
      end
      ST_LOAD_MID1: begin
        mid_ready = 1'b1;
        if (mid_valid) begin
          ld_en[SLOT_FIRST+1] = 1'b1;
          state_d = ST_LOAD_MID2;
        end
      end
      ST_LOAD_MID2: begin
        mid_ready = 1'b1;
        if (mid_valid) begin
          ld_en[SLOT_LAST-1] = 1'b1;
          state_d = ST_PRESENT;
        end
      end
      ST_PRESENT: begin
        m_valid = 1'b1;
        if (m_ready && (rd_idx_q == LAST_IDX)) state_d = ST_WAIT_ACK;
      end
      ST_WAIT_ACK: begin
        if (flt_ack) begin
          recycle = 1'b1;
          state_d = ST_LOAD_B;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign draining = (state_q == ST_PRESENT) || (state_q == ST_WAIT_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rd_idx_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ovf_q   <= s_valid && draining;
      if ((state_q == ST_PRESENT) && m_ready) begin
        rd_idx_q <= (rd_idx_q == LAST_IDX) ? '0 : rd_idx_q + 1'b1;
      end
    end
  end

  assign rd_idx = rd_idx_q;
  assign m_last = (state_q == ST_PRESENT) && (rd_idx_q == LAST_IDX);
  assign ovf    = ovf_q;
endmodule

// File: rtl/isb_slots.sv
module isb_slots
  import isb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SLOTS-1:0]              ld_en,
  input  logic                              recycle,
  input  logic [DATA_W-1:0]                 in_data,
  input  logic [DATA_W-1:0]                 mid_data,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  slot_q
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam bit IS_OUTER = (i == SLOT_FIRST) || (i == SLOT_LAST);
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] keep;

    if (IS_OUTER) begin : g_outer
      assign src = in_data;
    end else begin : g_inner
      assign src = mid_data;
    end

    if (i == SLOT_FIRST) begin : g_reuse
      assign keep = slot_q[SLOT_LAST];
    end else begin : g_clear
      assign keep = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (recycle) begin
        slot_q[i] <= keep;
      end else if (ld_en[i]) begin
        slot_q[i] <= src;
      end
    end
  end
endmodule

// File: rtl/isb_rd_mux.sv
module isb_rd_mux
  import isb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q,
  input  logic [IDX_W-1:0]                 rd_idx,
  output logic [DATA_W-1:0]                rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = slot_q[i];
    end
  end
endmodule

// File: rtl/interp_stage_buf.sv
module interp_stage_buf
  import isb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              pair_valid,
  input  logic              pair_ready,
  output logic [DATA_W-1:0] pair_a,
  output logic [DATA_W-1:0] pair_b,
  input  logic              mid_valid,
  output logic              mid_ready,
  input  logic [DATA_W-1:0] mid_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  input  logic              flt_ack,
  output logic              ovf
);
  logic [NUM_SLOTS-1:0]             ld_en;
  logic                             recycle;
  logic [IDX_W-1:0]                 rd_idx;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;

  isb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .pair_ready(pair_ready), .mid_valid(mid_valid),
    .m_ready(m_ready), .flt_ack(flt_ack),
    .s_ready(s_ready), .pair_valid(pair_valid), .mid_ready(mid_ready),
    .m_valid(m_valid), .m_last(m_last),
    .ld_en(ld_en), .recycle(recycle), .rd_idx(rd_idx), .ovf(ovf)
  );

  isb_slots #(.DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .recycle(recycle),
    .in_data(s_data), .mid_data(mid_data),
    .slot_q(slot_q)
  );

  isb_rd_mux #(.DATA_W(DATA_W)) u_mux (
    .slot_q(slot_q), .rd_idx(rd_idx), .rd_data(m_data)
  );

  assign pair_a = slot_q[SLOT_FIRST];
  assign pair_b = slot_q[SLOT_LAST];
endmodule

// File: rtl/isb_chk.sv
module isb_chk
  import isb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              pair_valid,
  input logic              pair_ready,
  input logic [DATA_W-1:0] pair_a,
  input logic [DATA_W-1:0] pair_b,
  input logic              mid_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_last,
  input logic              ovf
);
  logic [IDX_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else if (m_valid && m_ready) beat_q <= beat_q + 1'b1;
  end

  AST_ONE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s_ready, pair_valid, mid_ready, m_valid})); // R3
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !pair_ready) |=> (pair_valid && $stable(pair_a) && $stable(pair_b))); // R2
  AST_LAST_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_last == (beat_q == IDX_W'(SLOT_LAST)))); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last))); // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> (!m_valid && !s_ready)); // R7
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && m_valid) |=> ovf); // R9
  AST_OVF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready || pair_valid || mid_ready) |=> !ovf); // R9
endmodule

bind interp_stage_buf isb_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/interp_stage_buf_tb_top.sv
module interp_stage_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;
  localparam int GROUPS     = 40;

  logic          clk, rst_n;
  logic          s_valid, s_ready;
  logic [DW-1:0] s_data;
  logic          pair_valid, pair_ready;
  logic [DW-1:0] pair_a, pair_b;
  logic          mid_valid, mid_ready;
  logic [DW-1:0] mid_data;
  logic          m_valid, m_ready, m_last;
  logic [DW-1:0] m_data;
  logic          flt_ack, ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  interp_stage_buf #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .pair_valid(pair_valid), .pair_ready(pair_ready),
    .pair_a(pair_a), .pair_b(pair_b),
    .mid_valid(mid_valid), .mid_ready(mid_ready), .mid_data(mid_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .flt_ack(flt_ack), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] mid_of(input logic [DW-1:0] a,
                                           input logic [DW-1:0] b, input int k);
    logic [31:0] t;
    t = (32'(a) * 32'(3 - k) + 32'(b) * 32'(k)) / 32'd3;
    return t[DW-1:0];
  endfunction

  task automatic push_in(input logic [DW-1:0] x);
    bit hs;
    repeat ($urandom_range(0, 2)) @(negedge clk);
    s_valid = 1'b1;
    s_data  = x;
    forever begin
      hs = s_ready;
      @(negedge clk);
      if (hs) break;
    end
    s_valid = 1'b0;
  endtask

  task automatic push_mid(input logic [DW-1:0] x);
    bit hs;
    repeat ($urandom_range(0, 2)) @(negedge clk);
    mid_valid = 1'b1;
    mid_data  = x;
    forever begin
      hs = mid_ready;
      @(negedge clk);
      if (hs) break;
    end
    mid_valid = 1'b0;
  endtask

  task automatic serve_interp(input logic [DW-1:0] a, input logic [DW-1:0] b,
                              input bit probe);
    int guard = 0;
    while (!pair_valid && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    chk_eq("R2", "pair_valid", pair_valid, 1);
    chk_eq("R2", "pair_a", pair_a, a);
    chk_eq("R2", "pair_b", pair_b, b);
    repeat ($urandom_range(0, 3)) @(negedge clk);
    chk_eq("R2", "pair_a held", pair_a, a);
    chk_eq("R2", "pair_b held", pair_b, b);
    pair_ready = 1'b1;
    @(negedge clk);
    pair_ready = 1'b0;
    chk_eq("R4", "mid_ready after pair", mid_ready, 1);
    if (probe) begin
      s_valid = 1'b1;
      s_data  = DW'($urandom);
      @(negedge clk);
      chk_eq("R9", "ovf quiet while loading", ovf, 0);
      chk_eq("R3", "s_ready while loading", s_ready, 0);
      s_valid = 1'b0;
    end
    push_mid(mid_of(a, b, 1));
    chk_eq("R4", "mid_ready between words", mid_ready, 1);
    push_mid(mid_of(a, b, 2));
    chk_eq("R4", "mid_ready after two", mid_ready, 0);
  endtask

  task automatic drain(input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input bit early, input bit probe);
    logic [DW-1:0] exp_w [4];
    logic [DW-1:0] d;
    logic          lst;
    bit            hs;
    int            k = 0;
    exp_w[0] = a;
    exp_w[1] = mid_of(a, b, 1);
    exp_w[2] = mid_of(a, b, 2);
    exp_w[3] = b;
    while (k < 4) begin
      m_ready = ($urandom_range(0, 2) != 0);
      flt_ack = early && (k == 1);   // R10 early acknowledge
      chk_eq("R5", "m_valid", m_valid, 1);
      d   = m_data;
      lst = m_last;
      hs  = m_ready;
      @(negedge clk);
      if (hs) begin
        chk_eq("R5", "word", d, exp_w[k]);
        chk_eq("R5", "m_last", lst, (k == 3));
        k++;
      end else begin
        chk_eq("R6", "m_data held", m_data, d);
        chk_eq("R6", "m_valid held", m_valid, 1);
      end
    end
    m_ready = 1'b0;
    flt_ack = 1'b0;
    chk_eq("R7", "m_valid after last", m_valid, 0);
    chk_eq("R7", "s_ready before ack", s_ready, 0);
    if (probe) begin
      s_valid = 1'b1;
      s_data  = DW'($urandom);
      @(negedge clk);
      chk_eq("R9", "ovf raised", ovf, 1);
      chk_eq("R3", "no accept while draining", s_ready, 0);
      s_valid = 1'b0;
      @(negedge clk);
      chk_eq("R9", "ovf cleared", ovf, 0);
    end
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk);
      chk_eq("R7", "group held", {m_valid, s_ready}, 0);
    end
    flt_ack = 1'b1;
    @(negedge clk);
    flt_ack = 1'b0;
    chk_eq("R7", "s_ready after ack", s_ready, 1);
    chk_eq("R8", "pair_a reused", pair_a, b);
    chk_eq("R8", "pair_b cleared", pair_b, 0);
  endtask

  initial begin
    logic [DW-1:0] prev, cur;
    void'($urandom(32'd4711));
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; pair_ready = 1'b0;
    mid_valid = 1'b0; mid_data = '0; m_ready = 1'b0; flt_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1", "outputs in reset",
           {s_ready, pair_valid, mid_ready, m_valid, m_last, ovf}, 0);
    chk_eq("R1", "pair in reset", {pair_a, pair_b}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1", "s_ready after release", s_ready, 1);
    prev = DW'($urandom);
    push_in(prev);
    for (int g = 0; g < GROUPS; g++) begin
      if (g == 1)      cur = '0;
      else if (g == 2) cur = '1;
      else             cur = DW'($urandom);
      push_in(cur);   // R8: one new sample per later group
      serve_interp(prev, cur, (g % 6) == 3);
      drain(prev, cur, (g % 5) == 2, (g % 4) == 1);
      prev = cur;
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule